// File: doc/BRIEF.md
# Pointer-Selected Console Status Port

This block is a console serial interface that exposes two byte-wide ports on a simple access bus. One is a combined status/command port at offset 0x80 and the other is a data port at offset 0xC0. Software writes a byte to the status port, and that byte both selects what the next status read returns and may act as a command. The pointer is one-shot: once the interrupt-source selection has been read, the pointer falls back to zero.

Writing the data port hands one byte to the transmit side. Reading the data port takes one byte from a receive stream. The stream presents a valid flag, the byte itself, and a marker that says this byte is the last one waiting. Transmit and receive each have a pending-interrupt flag, and a single interrupt output is the OR of the two. Channel configuration, baud generation and the line protocol are outside the block.

Top module: `ptr_serial_port`

## Requirements
- R1: After reset both pending flags and the pointer are 0, so `irq` and `err` are low and a status read returns 0x04.
- R2: A status write stores its byte as the pointer. A status read with the pointer not equal to 3 returns 0x04, with bit 0 also set while a receive interrupt is pending, and leaves the pointer unchanged.
- R3: A status read with the pointer equal to 3 returns one of three values. It returns 0x10 if a transmit interrupt is pending. Otherwise it returns 0x20 if a receive interrupt is pending. Otherwise it returns 0x00. That read sets the pointer back to 0.
- R4: A data-port write presents the byte on `tx_byte` with `tx_valid` high in the same cycle, and sets the transmit pending flag from the next cycle on.
- R5: A status write of 0x28 while a transmit interrupt is pending clears that flag from the next cycle on.
- R6: A status write of 0x28 with no transmit interrupt pending raises `err` for exactly the following cycle and changes no flag.
- R7: A rising edge of `rx_valid` sets the receive pending flag from the next cycle on, with no enable condition.
- R8: A data-port read while `rx_valid` is high returns `rx_byte` and pulses `rx_pop` in the same cycle. If `rx_last` was high, the receive pending flag is cleared from the next cycle on.
- R9: A data-port read while `rx_valid` is low returns 0x00, does not pop, and raises `err` for exactly the following cycle.
- R10: `irq` is high exactly while the transmit or the receive pending flag is set.
- R11: Status writes of 0x00, 0x01 and 0x12 change only the pointer and leave both pending flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Port offset (0x80 status, 0xC0 data) |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive stream holds a byte |
| rx_byte | input | 8 | Head byte of the receive stream |
| rx_last | input | 1 | Head byte is the only one left |
| rx_pop | output | 1 | Consume the head byte |
| irq | output | 1 | Interrupt request |
| err | output | 1 | One-cycle misuse flag |

## Verification
The assertions assume three things about the receive source. First, it drops `rx_valid` after its last byte has been popped. Second, `rx_byte` and `rx_last` stay steady between pops. Third, at most one access arrives per cycle. The bench meets these by driving the receive pins from a queue. It refreshes those pins only between clock edges and only after the queue has been updated for a pop. Accesses are issued one per cycle from a single task.

// File: rtl/ptr_serial_port.sv
module ptr_serial_port #(
  parameter int          AW        = 8,
  parameter int          DW        = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'h80,
  parameter logic [AW-1:0] DATA_ADDR = 8'hC0,
  parameter logic [DW-1:0] ACK_CMD   = 8'h28,
  parameter logic [DW-1:0] SRC_PTR   = 8'h03,
  parameter int          TX_SRC_BIT  = 4,
  parameter int          RX_SRC_BIT  = 5,
  parameter int          ALIVE_BIT   = 2,
  parameter int          RX_STAT_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_last,
  output logic          rx_pop,
  output logic          irq,
  output logic          err
);

  logic [DW-1:0] ptr;
  logic          tx_pend, rx_pend, rx_seen;

  wire st_hit   = acc_en && (acc_addr == STAT_ADDR);
  wire dt_hit   = acc_en && (acc_addr == DATA_ADDR);
  wire st_wr    = st_hit && acc_wr;
  wire st_rd    = st_hit && !acc_wr;
  wire dt_wr    = dt_hit && acc_wr;
  wire dt_rd    = dt_hit && !acc_wr;
  wire ack      = st_wr && (acc_wdata == ACK_CMD);
  wire src_rd   = st_rd && (ptr == SRC_PTR);
  wire pop_last = rx_pop && rx_last;
  wire rx_rise  = rx_valid && !rx_seen;

  assign rx_pop   = dt_rd && rx_valid;
  assign tx_valid = dt_wr;
  assign tx_byte  = acc_wdata;
  assign irq      = tx_pend | rx_pend;

  always_comb begin
    acc_rdata = '0;
    if (src_rd) begin
      if (tx_pend)      acc_rdata[TX_SRC_BIT] = 1'b1;
      else if (rx_pend) acc_rdata[RX_SRC_BIT] = 1'b1;
    end else if (st_rd) begin
      acc_rdata[ALIVE_BIT]   = 1'b1;
      acc_rdata[RX_STAT_BIT] = rx_pend;
    end else if (rx_pop) begin
      acc_rdata = rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      tx_pend <= 1'b0;
      rx_pend <= 1'b0;
      rx_seen <= 1'b0;
      err     <= 1'b0;
    end else begin
      rx_seen <= rx_valid;
      err     <= (ack && !tx_pend) || (dt_rd && !rx_valid);
      if (st_wr)       ptr <= acc_wdata;
      else if (src_rd) ptr <= '0;
      if (dt_wr)    tx_pend <= 1'b1;
      else if (ack) tx_pend <= 1'b0;
      if (pop_last)     rx_pend <= 1'b0;
      else if (rx_rise) rx_pend <= 1'b1;
    end
  end

  a_r4_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dt_wr |=> irq);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && tx_pend) |=> !tx_pend);
  a_r6_bad_ack_err: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tx_pend) |=> (err && $stable(rx_pend)));
  a_r9_empty_read_err: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_rd && !rx_valid) |=> err);
  a_r3_ptr_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |=> (ptr == '0));
  a_r7_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rise && !pop_last) |=> irq);
  a_r8_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_valid);
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, rx_pop}));

endmodule

// File: tb/ptr_serial_port_tb.sv
module ptr_serial_port_tb;
  logic       clk = 0, rst_n = 0;
  logic       acc_en = 0, acc_wr = 0;
  logic [7:0] acc_addr = 0, acc_wdata = 0, acc_rdata;
  logic       tx_valid, rx_pop, irq, err;
  logic [7:0] tx_byte;
  logic       rx_valid = 0, rx_last = 0;
  logic [7:0] rx_byte = 0;

  always #10 clk = ~clk;

  ptr_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_last(rx_last), .rx_pop(rx_pop),
    .irq(irq), .err(err));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] q[$];
  int ptr = 0;
  bit txp = 0, rxp = 0, prevv = 0, errx = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit en, bit wr, logic [7:0] a, logic [7:0] d, string tag);
    int exp_rd;
    bit popped, poplast;
    @(negedge clk);
    chk("R10 irq", irq, txp | rxp);
    chk("R6/R9 err", err, errx);
    acc_en = en; acc_wr = wr; acc_addr = a; acc_wdata = d;
    rx_valid = q.size() > 0;
    rx_byte  = q.size() > 0 ? q[0] : 8'h00;
    rx_last  = q.size() == 1;
    exp_rd = 0;
    if (en && !wr && a == 8'h80)
      exp_rd = (ptr == 3) ? (txp ? 8'h10 : (rxp ? 8'h20 : 0)) : (8'h04 | rxp);
    else if (en && !wr && a == 8'hC0)
      exp_rd = q.size() > 0 ? q[0] : 0;
    #1;
    if (en && !wr) chk(tag, acc_rdata, exp_rd);
    chk("R4 tx_valid", tx_valid, en && wr && a == 8'hC0);
    if (en && wr && a == 8'hC0) chk("R4 tx_byte", tx_byte, d);
    chk("R8 rx_pop", rx_pop, en && !wr && a == 8'hC0 && q.size() > 0);
    @(posedge clk);
    errx = 0; popped = 0; poplast = 0;
    if (en && wr && a == 8'h80) begin
      ptr = d;
      if (d == 8'h28) begin if (txp) txp = 0; else errx = 1; end
    end else if (en && !wr && a == 8'h80) begin
      if (ptr == 3) ptr = 0;
    end else if (en && wr && a == 8'hC0) begin
      txp = 1;
    end else if (en && !wr && a == 8'hC0) begin
      if (q.size() > 0) begin
        popped = 1; poplast = q.size() == 1; void'(q.pop_front());
      end else errx = 1;
    end
    if (poplast) rxp = 0;
    else if (rx_valid && !prevv) rxp = 1;
    prevv = rx_valid;
  endtask

  task automatic idle(); cyc(0, 0, 8'h00, 8'h00, "idle"); endtask
  task automatic swr(logic [7:0] d); cyc(1, 1, 8'h80, d, "swr"); endtask
  task automatic srd(string tag); cyc(1, 0, 8'h80, 8'h00, tag); endtask
  task automatic dwr(logic [7:0] d); cyc(1, 1, 8'hC0, d, "dwr"); endtask
  task automatic drd(string tag); cyc(1, 0, 8'hC0, 8'h00, tag); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chk("R1 err after reset", err, 0);
    srd("R1 status after reset");
    dwr(8'h41);
    idle();
    swr(8'h03);
    srd("R3 tx source");
    srd("R3 pointer rewound, R2 plain status");
    swr(8'h28);
    idle();
    swr(8'h28);
    idle();
    swr(8'h03);
    srd("R3 nothing pending");
    q.push_back(8'h55); q.push_back(8'h66);
    idle(); idle();
    srd("R2 status with rx pending");
    swr(8'h07);
    srd("R2 pointer 7 plain status");
    srd("R2 pointer kept");
    swr(8'h03);
    srd("R3 rx source");
    dwr(8'h99);
    swr(8'h03);
    srd("R3 tx has priority");
    swr(8'h28);
    swr(8'h12); idle();
    swr(8'h01); idle();
    swr(8'h00); idle();
    srd("R11 flags kept");
    drd("R8 first byte");
    idle();
    drd("R8 last byte");
    idle();
    drd("R9 empty read");
    idle();
    q.push_back(8'hA5);
    idle(); idle();
    drd("R8 single byte");
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule